// File: doc/BRIEF.md
# Battery Temperature Zone Classifier

This block sorts a battery's temperature into one of six zones. It works from a digitized thermistor ratio, which is the voltage at the thermistor node as a fraction of the thermistor reference. A higher ratio means a colder battery. The six zones are, from cold to hot: below 0 °C (cold fault), 0–10 °C, 10–45 °C, 45–50 °C, 50–60 °C, and above 60 °C (hot fault). Each boundary has hysteresis. The two outer limits have a 10-degree band and the three inner boundaries have a 1-degree band, so a temperature that hovers near a boundary does not make the zone chatter.

The zone is a stored state. It changes only on a sample-valid strobe. A select input picks one of two threshold sets, one for a 10 kΩ thermistor and one for a 100 kΩ thermistor. From the current zone the block picks that zone's termination-voltage code and maximum-current code out of two packed configuration words. It raises charge-inhibit in the fault zones, for an open thermistor, and for an invalid termination-voltage code. An open thermistor is a ratio near full scale. It takes priority over classification and freezes the zone.

Top module: `thermzone_classifier`

## Requirements
- R1: After reset the zone output is 2 (10–45 °C), and open_flt, cold_flt and hot_flt are 0.
- R2: Zone codes are 0 cold, 1 for 0–10, 2 for 10–45, 3 for 45–50, 4 for 50–60 and 5 hot. The zone and open_flt registers load on a clock edge with sample_vld high; the result is visible after that edge. With sample_vld low, they hold whatever ratio_code does.
- R3: Cold limit. The block enters zone 0 when ratio_code >= 774 (therm_sel=0) or 824 (therm_sel=1). It leaves zone 0 only when ratio_code <= 681 or 715 respectively. cold_flt is high exactly in zone 0.
- R4: Hot limit. The block enters zone 5 when ratio_code <= 255 (therm_sel=0) or 199 (therm_sel=1). It leaves zone 5 only when ratio_code >= 315 or 276 respectively. hot_flt is high exactly in zone 5.
- R5: Inner boundaries, given as colder-entry (>=) / warmer-entry (<=) codes. For therm_sel=0: 10 °C 678/670, 45 °C 361/353, 50 °C 323/315. For therm_sel=1: 715/702, 331/321, 285/276. Between the two codes of a boundary, the side already held is kept.
- R6: therm_sel=0 selects the 10 kΩ threshold set and therm_sel=1 selects the 100 kΩ set. The select takes effect at the next strobed sample.
- R7: One strobed sample may move the zone across several boundaries. The zone lands where the hysteresis rules of every crossed boundary place it.
- R8: In charging zone k (1..4), vterm_code = zone_vt_cfg[3(k-1)+2 : 3(k-1)] and imax_code = zone_ic_cfg[4(k-1)+3 : 4(k-1)]. In zones 0 and 5, or while open_flt is high, both codes are 0.
- R9: chg_inhibit is high when cold_flt, hot_flt or open_flt is high, or when the selected vterm_code is 3'b111. Otherwise it is low.
- R10: A strobed ratio_code >= 1004 (98 % of full scale) sets open_flt and leaves the zone unchanged. The next strobed sample below 1004 clears open_flt and classifies normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_vld | input | 1 | Strobe: ratio_code holds a new sample |
| ratio_code | input | 10 | Thermistor ratio, full scale = 100 % |
| therm_sel | input | 1 | 0 = 10 kΩ set, 1 = 100 kΩ set |
| zone_vt_cfg | input | 12 | Four 3-bit termination-voltage codes, zone 1 lowest |
| zone_ic_cfg | input | 16 | Four 4-bit maximum-current codes, zone 1 lowest |
| zone | output | 3 | Current zone code |
| vterm_code | output | 3 | Selected termination-voltage code |
| imax_code | output | 4 | Selected maximum-current code |
| chg_inhibit | output | 1 | Charging must stop |
| cold_flt | output | 1 | Cold fault zone |
| hot_flt | output | 1 | Hot fault zone |
| open_flt | output | 1 | Open thermistor detected |

## Verification
On every cycle, the assertions check the following:
- the zone and open flag hold without a strobe;
- an open-thermistor sample freezes the zone;
- a fault always implies charge-inhibit, and a non-charging zone outputs zero codes;
- at each boundary the two trip comparisons never fire together;
- the next-state side bits stay ordered from cold to hot.

The exact trip and release codes of each boundary cannot be shown by a property. Neither can the landing zone after a multi-boundary jump, the switch between threshold sets, or the field selected for each zone. Those are shown only by the bench's directed walks through every band and by random samples clustered near the thresholds, compared against an independent reference model.

// File: rtl/thermzone_pkg.sv
package thermzone_pkg;

  localparam int unsigned NUM_BOUND = 5;
  localparam int unsigned NUM_CHG   = 4;
  localparam int unsigned ZONE_W    = 3;

  typedef enum logic [ZONE_W-1:0] {
    ZN_COLD  = 3'd0,
    ZN_0_10  = 3'd1,
    ZN_10_45 = 3'd2,
    ZN_45_50 = 3'd3,
    ZN_50_60 = 3'd4,
    ZN_HOT   = 3'd5
  } zone_e;

  // per-mille of full scale to a code of rw bits, rounded to nearest
  function automatic int unsigned pm_to_code(input int unsigned pm,
                                             input int unsigned rw);
    return (pm * (32'd1 << rw) + 32'd500) / 32'd1000;
  endfunction

  // zone index = number of boundaries on whose warm side the battery sits
  function automatic logic [ZONE_W-1:0] warm_count(
      input logic [NUM_BOUND-1:0] cold_side);
    logic [ZONE_W-1:0] n;
    n = '0;
    for (int i = 0; i < int'(NUM_BOUND); i++) begin
      if (!cold_side[i]) n = n + 1'b1;
    end
    return n;
  endfunction

endpackage

// File: rtl/thermzone_bound.sv
module thermzone_bound #(
  parameter int unsigned RW     = 10,
  parameter int unsigned COLD_A = 756,
  parameter int unsigned WARM_A = 665,
  parameter int unsigned COLD_B = 805,
  parameter int unsigned WARM_B = 698
) (
  input  logic [RW-1:0] ratio,
  input  logic          sel,
  input  logic          cur_cold,
  output logic          nxt_cold,
  output logic          hit_cold,
  output logic          hit_warm
);

  localparam logic [RW-1:0] TC_A = RW'(thermzone_pkg::pm_to_code(COLD_A, RW));
  localparam logic [RW-1:0] TW_A = RW'(thermzone_pkg::pm_to_code(WARM_A, RW));
  localparam logic [RW-1:0] TC_B = RW'(thermzone_pkg::pm_to_code(COLD_B, RW));
  localparam logic [RW-1:0] TW_B = RW'(thermzone_pkg::pm_to_code(WARM_B, RW));

  logic [RW-1:0] th_cold, th_warm;

  assign th_cold  = sel ? TC_B : TC_A;
  assign th_warm  = sel ? TW_B : TW_A;
  assign hit_cold = (ratio >= th_cold);
  assign hit_warm = (ratio <= th_warm);
  assign nxt_cold = hit_cold | (cur_cold & ~hit_warm);

endmodule

// File: rtl/thermzone_fields.sv
module thermzone_fields #(
  parameter int unsigned VT_W = 3,
  parameter int unsigned IC_W = 4,
  parameter int unsigned NCHG = 4,
  parameter int unsigned ZW   = 3
) (
  input  logic [ZW-1:0]        zone,
  input  logic                 pass,
  input  logic [VT_W*NCHG-1:0] vt_cfg,
  input  logic [IC_W*NCHG-1:0] ic_cfg,
  output logic [VT_W-1:0]      vterm,
  output logic [IC_W-1:0]      imax
);

  always_comb begin
    vterm = '0;
    imax  = '0;
    if (pass) begin
      for (int k = 0; k < int'(NCHG); k++) begin
        if (zone == ZW'(k + 1)) begin
          vterm = vt_cfg[k*VT_W +: VT_W];
          imax  = ic_cfg[k*IC_W +: IC_W];
        end
      end
    end
  end

endmodule

// File: rtl/thermzone_classifier.sv
module thermzone_classifier
  import thermzone_pkg::*;
#(
  parameter int unsigned RW      = 10,
  parameter int unsigned VT_W    = 3,
  parameter int unsigned IC_W    = 4,
  parameter int unsigned OPEN_PM = 980,
  parameter int unsigned COLD_PM_A [NUM_BOUND] = '{756, 662, 353, 315, 308},
  parameter int unsigned WARM_PM_A [NUM_BOUND] = '{665, 654, 345, 308, 249},
  parameter int unsigned COLD_PM_B [NUM_BOUND] = '{805, 698, 323, 278, 270},
  parameter int unsigned WARM_PM_B [NUM_BOUND] = '{698, 686, 313, 270, 194}
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sample_vld,
  input  logic [RW-1:0]           ratio_code,
  input  logic                    therm_sel,
  input  logic [VT_W*NUM_CHG-1:0] zone_vt_cfg,
  input  logic [IC_W*NUM_CHG-1:0] zone_ic_cfg,
  output logic [ZONE_W-1:0]       zone,
  output logic [VT_W-1:0]         vterm_code,
  output logic [IC_W-1:0]         imax_code,
  output logic                    chg_inhibit,
  output logic                    cold_flt,
  output logic                    hot_flt,
  output logic                    open_flt
);

  localparam logic [RW-1:0] OPEN_CODE = RW'(pm_to_code(OPEN_PM, RW));

  logic [ZONE_W-1:0]    zone_q, zone_nxt;
  logic                 open_q, open_hit;
  logic [NUM_BOUND-1:0] cur_cold, nxt_cold, hit_c, hit_w;
  logic                 in_chg, vt_bad;

  // one hysteretic comparator pair per boundary, 0 = coldest
  for (genvar b = 0; b < int'(NUM_BOUND); b++) begin : g_bound
    assign cur_cold[b] = (zone_q <= ZONE_W'(b));
    thermzone_bound #(
      .RW(RW), .COLD_A(COLD_PM_A[b]), .WARM_A(WARM_PM_A[b]),
      .COLD_B(COLD_PM_B[b]), .WARM_B(WARM_PM_B[b])
    ) u_bnd (
      .ratio(ratio_code), .sel(therm_sel), .cur_cold(cur_cold[b]),
      .nxt_cold(nxt_cold[b]), .hit_cold(hit_c[b]), .hit_warm(hit_w[b])
    );

    // R5: the two trip points of one boundary never fire together
    a_r5_trip_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit_c[b] && hit_w[b]));

    if (b + 1 < int'(NUM_BOUND)) begin : g_order
      // R7: a colder boundary on its cold side implies the next one is too
      a_r7_side_order: assert property (@(posedge clk) disable iff (!rst_n)
        nxt_cold[b] |-> nxt_cold[b+1]);
    end
  end

  assign open_hit = (ratio_code >= OPEN_CODE);
  assign zone_nxt = warm_count(nxt_cold);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zone_q <= ZN_10_45;
      open_q <= 1'b0;
    end else if (sample_vld) begin
      open_q <= open_hit;
      if (!open_hit) zone_q <= zone_nxt;
    end
  end

  assign zone     = zone_q;
  assign cold_flt = (zone_q == ZN_COLD);
  assign hot_flt  = (zone_q == ZN_HOT);
  assign open_flt = open_q;
  assign in_chg   = !cold_flt && !hot_flt && !open_q;

  thermzone_fields #(
    .VT_W(VT_W), .IC_W(IC_W), .NCHG(NUM_CHG), .ZW(ZONE_W)
  ) u_fields (
    .zone(zone_q), .pass(in_chg), .vt_cfg(zone_vt_cfg), .ic_cfg(zone_ic_cfg),
    .vterm(vterm_code), .imax(imax_code)
  );

  assign vt_bad      = in_chg && (vterm_code == {VT_W{1'b1}});
  assign chg_inhibit = !in_chg || vt_bad;

  // R2: no strobe, no state change
  a_r2_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_vld |=> $stable(zone_q) && $stable(open_q));

  // R2: zone code never leaves the six defined values
  a_r2_zone_range: assert property (@(posedge clk) disable iff (!rst_n)
    zone_q <= ZN_HOT);

  // R10: open thermistor freezes classification
  a_r10_open_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld && open_hit) |=> open_q && $stable(zone_q));

  // R3: cold trip lands in the cold zone
  a_r3_cold_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld && !open_hit && hit_c[0]) |=> cold_flt);

  // R4: hot trip lands in the hot zone
  a_r4_hot_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld && hit_w[NUM_BOUND-1]) |=> hot_flt);

  // R9: any fault inhibits charging
  a_r9_fault_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    (cold_flt || hot_flt || open_flt) |-> chg_inhibit);

  // R8: non-charging zones publish zero codes
  a_r8_zero_fields: assert property (@(posedge clk) disable iff (!rst_n)
    !in_chg |-> (vterm_code == '0) && (imax_code == '0));

endmodule

// File: tb/sim_thermzone_classifier.sv
module sim_thermzone_classifier;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample_vld = 1'b0;
  logic [9:0]  ratio_code = 10'd500;
  logic        therm_sel = 1'b0;
  logic [11:0] zone_vt_cfg = {3'd4, 3'd3, 3'd2, 3'd1};
  logic [15:0] zone_ic_cfg = {4'd8, 4'd7, 4'd6, 4'd5};
  logic [2:0]  zone;
  logic [2:0]  vterm_code;
  logic [3:0]  imax_code;
  logic        chg_inhibit, cold_flt, hot_flt, open_flt;

  always #(CLK_P/2) clk = ~clk;

  thermzone_classifier u0 (
    .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld), .ratio_code(ratio_code),
    .therm_sel(therm_sel), .zone_vt_cfg(zone_vt_cfg), .zone_ic_cfg(zone_ic_cfg),
    .zone(zone), .vterm_code(vterm_code), .imax_code(imax_code),
    .chg_inhibit(chg_inhibit), .cold_flt(cold_flt), .hot_flt(hot_flt),
    .open_flt(open_flt)
  );

  // colder-entry (>=) and warmer-entry (<=) codes, boundary 0 = 0 degC
  int cold_tab [2][5] = '{'{774, 678, 361, 323, 315}, '{824, 715, 331, 285, 276}};
  int warm_tab [2][5] = '{'{681, 670, 353, 315, 255}, '{715, 702, 321, 276, 199}};
  localparam int OPEN_TH = 1004;

  int nvec = 0;
  int nfail = 0;
  int rz = 2;
  bit ropen = 1'b0;

  // reference: walk one zone at a time while a crossing applies
  function automatic int walk(input int z, input int r, input int s);
    int zz = z;
    for (int step = 0; step < 6; step++) begin
      if (zz > 0 && r >= cold_tab[s][zz-1]) zz = zz - 1;
      else if (zz < 5 && r <= warm_tab[s][zz]) zz = zz + 1;
    end
    return zz;
  endfunction

  task automatic check(input string tag);
    int ev, ei;
    bit ecold, ehot, einh;
    ev = 0; ei = 0;
    ecold = (rz == 0);
    ehot  = (rz == 5);
    if (!ropen && rz >= 1 && rz <= 4) begin
      ev = int'(zone_vt_cfg[3*(rz-1) +: 3]);
      ei = int'(zone_ic_cfg[4*(rz-1) +: 4]);
    end
    einh = ecold || ehot || ropen || (ev == 7);
    nvec++;
    if (int'(zone) != rz || int'(vterm_code) != ev || int'(imax_code) != ei ||
        chg_inhibit != einh || cold_flt != ecold || hot_flt != ehot ||
        open_flt != ropen) begin
      nfail++;
      $display("FAIL %s ratio=%0d sel=%0d: zone %0d exp %0d, vt %0d exp %0d, ic %0d exp %0d, inh %0b exp %0b, cold %0b exp %0b, hot %0b exp %0b, open %0b exp %0b",
               tag, ratio_code, therm_sel, zone, rz, vterm_code, ev, imax_code, ei,
               chg_inhibit, einh, cold_flt, ecold, hot_flt, ehot, open_flt, ropen);
    end
  endtask

  task automatic sample(input int r, input int s, input string tag);
    @(negedge clk);
    ratio_code = 10'(r);
    therm_sel  = s[0];
    sample_vld = 1'b1;
    @(negedge clk);
    sample_vld = 1'b0;
    if (r >= OPEN_TH) ropen = 1'b1;
    else begin
      ropen = 1'b0;
      rz = walk(rz, r, s);
    end
    check(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run did not finish, got hung exp done");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4551));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset state");

    // R5 inner boundaries, 10k set
    sample(677, 0, "R5 below 10C trip");
    sample(678, 0, "R5 10C trip");
    sample(671, 0, "R5 inside 10C band");
    sample(670, 0, "R5 11C release");
    sample(353, 0, "R5 45C trip");
    sample(360, 0, "R5 inside 45C band");
    sample(361, 0, "R5 44C release");
    sample(353, 0, "R5 45C trip again");
    sample(315, 0, "R5 50C trip");
    sample(322, 0, "R5 inside 50C band");
    sample(323, 0, "R5 49C release");
    // R4 / R7
    sample(255, 0, "R4 R7 hot trip from zone 3");
    sample(314, 0, "R4 inside hot band");
    sample(315, 0, "R4 hot release");
    // R3 / R7
    sample(774, 0, "R3 R7 cold trip from zone 4");
    sample(700, 0, "R3 inside cold band");
    sample(681, 0, "R3 cold release");
    // R6 100k set
    sample(700, 1, "R6 100k 11C release");
    sample(715, 1, "R6 100k 10C trip");
    sample(823, 1, "R6 100k below cold trip");
    sample(824, 1, "R6 R3 100k cold trip");
    sample(716, 1, "R6 R3 100k cold band");
    sample(715, 1, "R6 R3 100k cold release");
    sample(199, 1, "R6 R4 100k hot trip");
    sample(275, 1, "R6 R4 100k hot band");
    sample(276, 1, "R6 R4 100k hot release");
    // R10 open thermistor
    sample(1004, 1, "R10 open set zone held");
    sample(1023, 0, "R10 open full scale");
    sample(1003, 0, "R10 open clear");
    // R2 no strobe
    @(negedge clk);
    ratio_code = 10'd100;
    repeat (3) @(negedge clk);
    check("R2 ratio ignored without strobe");
    // R8 / R9 invalid code in zone 2
    sample(500, 0, "R8 back to zone 2");
    zone_vt_cfg[5:3] = 3'b111;
    #1;
    check("R9 invalid vterm inhibits");
    zone_vt_cfg[5:3] = 3'b110;
    #1;
    check("R8 zone 2 fields");

    // random, clustered near thresholds
    for (int i = 0; i < 4000; i++) begin
      int r, s;
      if (i % 50 == 0) begin
        zone_vt_cfg = 12'($urandom);
        zone_ic_cfg = 16'($urandom);
      end
      s = (($urandom % 16) == 0) ? int'(!therm_sel) : int'(therm_sel);
      if ($urandom % 2 == 0) r = int'($urandom % 1024);
      else begin
        int bi = int'($urandom % 5);
        int d  = int'($urandom % 7) - 3;
        r = (($urandom % 2) == 0) ? cold_tab[s][bi] + d : warm_tab[s][bi] + d;
        if (($urandom % 40) == 0) r = OPEN_TH - 1 + int'($urandom % 3);
      end
      if (r < 0) r = 0;
      if (r > 1023) r = 1023;
      sample(r, s, "R2 R7 R8 R9 random");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule